// File: doc/BRIEF.md
# Segmented PWM Generator with Even Remainder Spreading

This block produces a one-bit PWM output whose frame is 2^CNT_W clocks long, which gives a duty resolution of one clock per frame (about 1 ppm with the default 20-bit counter). The frame is not a single pulse. It is cut into 4 or 8 chunks of equal length, so the ripple seen by a downstream low-pass filter sits at 4 or 8 times the frame rate. With a 200 MHz clock the default frame lasts about 5 ms.

Each chunk opens with a high pulse and spends the rest of its length low. Every chunk gets the base share of the duty word, which is the duty divided by the chunk count. The leftover counts (duty modulo the chunk count) each add one clock to a different chunk. A chunk receives an extra clock when its bit-reversed index is below the leftover, so two extras fall in chunks that are not next to each other. Nothing is random, and the number of edges per frame does not depend on the duty word, except at the two ends of the range.

The duty word and the chunk-count select are captured only at a frame boundary. A one-clock strobe marks the first clock of each frame.

Top module: `pwm_seg_top`

## Requirements
- R1: The frame is exactly 2^CNT_W clocks long, and `frame_o` is high for one clock at the first clock of every frame and low otherwise.
- R2: `seg_sel_i` = 0 selects 4 chunks and `seg_sel_i` = 1 selects 8 chunks. Each chunk is 2^CNT_W/N clocks long and holds at most one high pulse, which starts on the chunk's first clock.
- R3: Chunk k is high for floor(D/N) clocks, plus one if it receives an extra clock, where D is the captured duty. The sum over a frame equals D.
- R4: Chunk k (counting from 0 at frame start) receives an extra clock exactly when the bit-reversal of k, over log2(N) bits, is less than D mod N. For example, with N = 4 and a remainder of 2, chunks 0 and 2 receive the extras.
- R5: `duty_i` and `seg_sel_i` are sampled only on the last clock of a frame. A change made mid-frame has no effect until the next frame.
- R6: D = 0 keeps `pwm_o` low for the whole frame. D >= 2^CNT_W is clamped to 2^CNT_W and keeps `pwm_o` high for the whole frame. Neither case produces a glitch pulse.
- R7: While reset is asserted, `pwm_o` and `frame_o` are low. The first frame after reset uses D = 0 with 4 chunks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| duty_i | input | CNT_W+1 | Requested high time per frame, in clocks |
| seg_sel_i | input | 1 | Chunk count select: 0 gives 4 chunks, 1 gives 8 |
| pwm_o | output | 1 | PWM output bit |
| frame_o | output | 1 | One-clock strobe on the first clock of each frame |

## Verification
A wrong frame counter first shows up at the next `frame_o`, which comes at the wrong spacing. A wrong captured duty or mode shows up in the first chunk after the boundary: the pulse has the wrong width, or the next chunk begins at the wrong place. A wrong bit-reversal or remainder comparison moves a single extra clock from one chunk to another while leaving the frame total correct. For that reason the bench compares every sample of the frame against the waveform computed from the requirements, not just the high-time total. A capture that leaks mid-frame changes the frame that is already running, and the bench looks for this right after it changes the inputs.

// File: rtl/pwm_seg_pkg.sv
package pwm_seg_pkg;

  // chunk-count selection, decoded from seg_sel_i
  typedef enum logic {
    SEG4 = 1'b0,
    SEG8 = 1'b1
  } seg_mode_e;

  // log2 of the chunk count for each mode
  localparam int unsigned LG_SEG4 = 2;
  localparam int unsigned LG_SEG8 = 3;

endpackage

// File: rtl/frame_timer.sv
module frame_timer #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o,
  output logic             frame_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             frame_q, frame_d;

  always_comb begin
    cnt_d   = cnt_q + 1'b1;
    frame_d = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      frame_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      frame_q <= frame_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign last_o  = &cnt_q;
  assign frame_o = frame_q;

  // R1
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_q |=> !frame_q);

endmodule

// File: rtl/duty_shadow.sv
module duty_shadow
  import pwm_seg_pkg::*;
#(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned DUTY_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              sel_i,
  output logic [DUTY_W-1:0] duty_o,
  output seg_mode_e         mode_o
);

  localparam logic [DUTY_W-1:0] FULL = DUTY_W'(1) << CNT_W;

  logic [DUTY_W-1:0] duty_q, duty_d;
  seg_mode_e         mode_q, mode_d;

  always_comb begin
    duty_d = duty_q;
    mode_d = mode_q;
    if (load_i) begin
      duty_d = (duty_i > FULL) ? FULL : duty_i;
      mode_d = sel_i ? SEG8 : SEG4;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      mode_q <= SEG4;
    end else begin
      duty_q <= duty_d;
      mode_q <= mode_d;
    end
  end

  assign duty_o = duty_q;
  assign mode_o = mode_q;

  // R5
  hold_midframe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(duty_q) && $stable(mode_q)));

endmodule

// File: rtl/chunk_shaper.sv
module chunk_shaper
  import pwm_seg_pkg::*;
#(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned DUTY_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  seg_mode_e         mode_i,
  output logic              pwm_o
);

  localparam logic [DUTY_W-1:0] FULL = DUTY_W'(1) << CNT_W;

  logic [1:0] hi_var;
  logic       pwm_q, pwm_d;

  // one level evaluator per chunk-count variant
  for (genvar v = 0; v < 2; v++) begin : g_var
    localparam int unsigned LG = (v == 0) ? LG_SEG4 : LG_SEG8;
    localparam int unsigned PW = CNT_W - LG;

    logic [LG-1:0]     idx;
    logic [LG-1:0]     idx_rev;
    logic [LG-1:0]     rem;
    logic [PW-1:0]     pos;
    logic [DUTY_W-1:0] base;
    logic [DUTY_W-1:0] high_len;
    logic              extra;
    logic              hi;

    always_comb begin
      idx  = cnt_i[CNT_W-1 -: LG];
      pos  = cnt_i[PW-1:0];
      base = duty_i >> LG;
      rem  = duty_i[LG-1:0];
      for (int i = 0; i < int'(LG); i++) begin
        idx_rev[i] = idx[int'(LG) - 1 - i];
      end
      extra    = (idx_rev < rem);
      high_len = base + DUTY_W'(extra);
      hi       = (DUTY_W'(pos) < high_len);
    end

    assign hi_var[v] = hi;
  end

  always_comb begin
    pwm_d = (mode_i == SEG8) ? hi_var[1] : hi_var[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
    end else begin
      pwm_q <= pwm_d;
    end
  end

  assign pwm_o = pwm_q;

  // R6
  zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_i == '0) |=> !pwm_q);

  // R6
  full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_i == FULL) |=> pwm_q);

endmodule

// File: rtl/pwm_seg_top.sv
module pwm_seg_top
  import pwm_seg_pkg::*;
#(
  parameter int unsigned CNT_W = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CNT_W:0] duty_i,
  input  logic           seg_sel_i,
  output logic           pwm_o,
  output logic           frame_o
);

  localparam int unsigned DUTY_W = CNT_W + 1;

  logic [1:0]        rst_sync_q;
  logic              srst_n;
  logic [CNT_W-1:0]  cnt;
  logic              last;
  logic [DUTY_W-1:0] duty_q;
  seg_mode_e         mode_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign srst_n = rst_sync_q[1];

  frame_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (srst_n),
    .cnt_o   (cnt),
    .last_o  (last),
    .frame_o (frame_o)
  );

  duty_shadow #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_shadow (
    .clk    (clk),
    .rst_n  (srst_n),
    .load_i (last),
    .duty_i (duty_i),
    .sel_i  (seg_sel_i),
    .duty_o (duty_q),
    .mode_o (mode_q)
  );

  chunk_shaper #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_shaper (
    .clk    (clk),
    .rst_n  (srst_n),
    .cnt_i  (cnt),
    .duty_i (duty_q),
    .mode_i (mode_q),
    .pwm_o  (pwm_o)
  );

  // R4
  first_chunk_chk: assert property (@(posedge clk) disable iff (!srst_n)
    frame_o |-> (pwm_o == (duty_q != '0)));

  // R2
  rise_at_chunk_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(pwm_o) |-> ((mode_q == SEG8) ? (cnt[CNT_W-4:0] == (CNT_W-3)'(1))
                                       : (cnt[CNT_W-3:0] == (CNT_W-2)'(1))));

endmodule

// File: tb/pwm_seg_top_tb_top.sv
module pwm_seg_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CW         = 8;
  localparam int FRAME      = 1 << CW;
  localparam int WDOG       = 60000;

  typedef struct {
    int    duty;
    int    sel;
    string tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [CW:0] duty_i;
  logic        seg_sel_i;
  logic        pwm_o;
  logic        frame_o;

  item_t exp_q[$];
  int    n_tests = 0;
  int    n_fail  = 0;
  bit    finished = 0;

  pwm_seg_top #(.CNT_W(CW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .duty_i    (duty_i),
    .seg_sel_i (seg_sel_i),
    .pwm_o     (pwm_o),
    .frame_o   (frame_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference level for a sample, from the requirements
  function automatic bit exp_bit(input int duty, input int sel, input int pos);
    int lg   = sel ? 3 : 2;
    int n    = 1 << lg;
    int len  = FRAME / n;
    int k    = pos / len;
    int p    = pos % len;
    int d    = (duty > FRAME) ? FRAME : duty;
    int base = d / n;
    int rem  = d % n;
    int rev  = 0;
    for (int i = 0; i < lg; i++) begin
      if (((k >> i) & 1) != 0) rev = rev | (1 << (lg - 1 - i));
    end
    return p < (base + ((rev < rem) ? 1 : 0));
  endfunction

  task automatic wait_frame();
    do @(negedge clk); while (!frame_o);
  endtask

  task automatic apply(input int duty, input int sel, input string tag);
    item_t it;
    wait_frame();
    duty_i    = (CW+1)'(duty);
    seg_sel_i = sel[0];
    it.duty = duty; it.sel = sel; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // R5: second setting changes in the middle of the frame using the first
  task automatic apply_mid(input int d1, input int s1, input int d2, input int s2);
    item_t it;
    apply(d1, s1, "R5");
    wait_frame();
    repeat (FRAME/2 - 3) @(negedge clk);
    duty_i    = (CW+1)'(d2);
    seg_sel_i = s2[0];
    it.duty = d2; it.sel = s2; it.tag = "R5";
    exp_q.push_back(it);
  endtask

  // monitor: pops one expected frame per strobe and compares every sample
  initial begin
    item_t cur;
    bit    started = 0;
    int    pos = 0;
    int    mism = 0;
    int    first_pos = 0;
    forever begin
      @(negedge clk);
      if (rst_n && !finished) begin
        if (frame_o) begin
          if (started) begin
            check(pos == FRAME, "R1 frame period", pos, FRAME);
            check(mism == 0, $sformatf("%s waveform duty=%0d sel=%0d first bad pos=%0d (mismatches)",
                  cur.tag, cur.duty, cur.sel, first_pos), mism, 0);
          end
          if (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
          end else begin
            check(1'b0, "R1 unexpected frame", 0, 1);
          end
          started = 1; pos = 0; mism = 0; first_pos = 0;
        end
        if (started) begin
          if (pwm_o !== exp_bit(cur.duty, cur.sel, pos)) begin
            if (mism == 0) first_pos = pos;
            mism++;
          end
          pos++;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(1'b0, "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // driver
  initial begin
    item_t it;
    duty_i    = '0;
    seg_sel_i = 1'b0;
    rst_n     = 1'b0;
    it.duty = 0; it.sel = 0; it.tag = "R7";
    exp_q.push_back(it);
    repeat (5) @(negedge clk);
    check(pwm_o == 1'b0, "R7 pwm in reset", int'(pwm_o), 0);
    check(frame_o == 1'b0, "R7 strobe in reset", int'(frame_o), 0);
    duty_i = (CW+1)'(77);
    rst_n  = 1'b1;
    exp_q[0].duty = 0;

    apply(100, 0, "R3");
    apply(101, 0, "R3");
    apply(102, 0, "R4");
    apply(103, 0, "R4");
    apply(1,   0, "R4");
    apply(37,  1, "R2");
    apply(130, 1, "R4");
    apply(255, 1, "R3");
    apply(0,   0, "R6");
    apply(256, 0, "R6");
    apply(511, 1, "R6");
    apply_mid(50, 0, 200, 1);
    apply(60,  1, "R2");
    apply(60,  1, "R2");
    wait_frame();
    @(negedge clk);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule